// File: doc/BRIEF.md
# Quad-channel double-buffered serial DAC controller

This block is the digital front end of a four-channel, 16-bit converter. A host writes 24-bit command frames on a three-wire serial port: an active-low frame strobe (`sync_n`), a serial clock (`sclk`) and a data line (`sdin`). Each channel keeps a pending input register and a live data register. A write fills the input register. The data register takes the new value either at the end of the frame, when the load pin is low, or later on a falling edge of the load pin, which moves every channel at once. The block also holds a gain register and an offset register for each channel, plus a two-bit general-purpose I/O port. The host can read all of these back through `sdo`. When no readback is pending, `sdo` passes the previous frame through, so several devices can be chained.

Every serial and control pin is resynchronised into `clk` through a two-flop chain. Edges are then detected in the clock domain. A receive state machine has three states. IDLE waits for the strobe to fall and then moves to SHIFT. SHIFT takes one bit on each falling edge of the serial clock and drives `sdo` on each rising edge; when the strobe rises it moves to DONE. DONE lasts one cycle. It commits the frame only if the bit count is a whole non-zero number of 24-bit words. On a read it loads the answer for the next frame, and it always returns to IDLE. Each channel outputs its code in offset-binary form. A clamp input forces every output to the mid code without touching any register.

Top module: `quad_dac_ctrl`

## Requirements
- R1: A frame starts when `sync_n` falls. `sdin` is taken on each falling `sclk` edge while the frame is open, most significant bit first. Frame fields: bit 23 is read (1) or write (0); bits 22:19 select the register (0 no-op, 1 data, 2 gain, 3 offset, 4 function/IO); bits 18:16 select the channel (0 to 3); bits 15:0 are the payload.
- R2: If `load_n` is low when the frame ends, a data write updates both the input and data registers of the addressed channel. The data register changes only on a committed frame, a load edge or a clear.
- R3: If `load_n` is high when the frame ends, a data write changes only the input register. The next falling edge of `load_n` copies every input register into its data register in the same cycle.
- R4: Channel code 4 addresses all channels at once. Channel codes 5 to 7 address none.
- R5: A falling edge of `clr_n` sets every data register to 0x0000. This gives output 0x8000 in two's-complement mode and 0x0000 in offset-binary mode. Clear wins over any update in the same cycle.
- R6: With `code_ob` high, a channel's output equals its stored code. With `code_ob` low, the output is the stored code with its MSB inverted.
- R7: While `hold_n` is low, `clamp` is 1 and every output is 0x8000. Registers keep their values and still accept writes, and the outputs return to the stored codes when `hold_n` rises.
- R8: A frame whose bit count is not a non-zero multiple of 24 changes no register. A 48-bit frame is accepted and acts on its last 24 bits.
- R9: During a frame, `sdo` presents, MSB first, the 24-bit word held from the previous frame. It changes only at frame start and after rising `sclk` edges.
- R10: After a read frame, the next frame shifts out on `sdo` the read frame's bits 23:16 followed by the 16-bit contents of the named register. A data-register read returns the stored, unconverted code.
- R11: Each channel's gain and offset registers can be written and read back independently.
- R12: A function write sets the I/O directions from payload bits 3:2 (1 = output) and the output values from bits 1:0. Its readback returns the directions in bits 3:2 and the pin levels in bits 1:0: the driven value for an output bit, the `io_in` level for an input bit.
- R13: After reset, every register is zero, `sdo` is 0, `io_oe` is 0 and `clamp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Active-low frame strobe |
| sclk | input | 1 | Serial clock; data taken on falling edge |
| sdin | input | 1 | Serial data in |
| load_n | input | 1 | Load pin; low = update at frame end, falling edge = load all |
| clr_n | input | 1 | Clear; falling edge zeroes all data registers |
| code_ob | input | 1 | Coding select: 1 offset binary, 0 two's complement |
| hold_n | input | 1 | Active-low output clamp |
| io_in | input | IO_W | Levels seen on the I/O pins |
| sdo | output | 1 | Serial data out (chain pass-through or readback) |
| io_out | output | IO_W | I/O output values |
| io_oe | output | IO_W | I/O direction, 1 = drive |
| clamp | output | 1 | High while outputs are clamped |
| ch_code | output | NCH*CODE_W | Per-channel offset-binary codes, channel 0 in the low bits |

## Verification
A data register that holds the wrong value shows on its `ch_code` lane within a few cycles of the strobe rising or the load pin falling. The bench compares every lane on every clock once the pins have settled, so an input register that was skipped or overwritten is exposed the moment a load edge copies it. Wrong state in the receive machine, such as a miscounted bit or a missed commit, shows as a register that did not change, or changed when it should not have, after the frame. Bad `sdo` content shows during the very next frame, when the bench captures the pass-through or readback word bit by bit before each falling `sclk` edge.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // register select field of a command frame
    typedef enum logic [3:0] {
        SEL_NOP  = 4'd0,
        SEL_DATA = 4'd1,
        SEL_GAIN = 4'd2,
        SEL_OFFS = 4'd3,
        SEL_FUNC = 4'd4
    } regsel_e;

    // receive state machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } rx_state_e;

    localparam logic [2:0] CH_ALL = 3'd4;
    localparam int HDR_W = 8;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import qdac_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_fall_i,
    input  logic                     sync_rise_i,
    input  logic                     sclk_fall_i,
    input  logic                     sclk_rise_i,
    input  logic                     sdin_i,
    input  logic [CODE_W-1:0]        rd_data_i,
    output logic [CODE_W+HDR_W-1:0]  frame_o,
    output logic                     frame_ok_o,
    output logic                     sdo_o
);

    localparam int FW    = CODE_W + HDR_W;
    localparam int CNT_W = $clog2(FW);

    rx_state_e         state_q, state_d;
    logic [FW-1:0]     sreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              full_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sync_fall_i) state_d = ST_SHIFT;
            ST_SHIFT: if (sync_rise_i) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // commit only on a whole, non-zero number of words
    assign frame_ok_o = (state_q == ST_DONE) && (cnt_q == '0) && full_q;
    assign frame_o    = sreg_q;

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
            sdo_o  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sync_fall_i) begin
                        cnt_q  <= '0;
                        full_q <= 1'b0;
                        sdo_o  <= sreg_q[FW-1];
                    end
                end
                ST_SHIFT: begin
                    if (sclk_fall_i) begin
                        sreg_q <= {sreg_q[FW-2:0], sdin_i};
                        if (cnt_q == CNT_W'(FW-1)) begin
                            cnt_q  <= '0;
                            full_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    if (sclk_rise_i) sdo_o <= sreg_q[FW-1];
                end
                ST_DONE: begin
                    if (frame_ok_o && sreg_q[FW-1])
                        sreg_q <= {sreg_q[FW-1:CODE_W], rd_data_i};
                end
                default: ;
            endcase
        end
    end

    // R1
    bit_count_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sclk_fall_i) |=> (cnt_q != $past(cnt_q)));

    // R9
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((state_q == ST_SHIFT && sclk_rise_i) || (state_q == ST_IDLE && sync_fall_i))
        |=> $stable(sdo_o));

endmodule

// File: rtl/qdac_regfile.sv
module qdac_regfile
    import qdac_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 16,
    parameter int IO_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_ok_i,
    input  logic [CODE_W+HDR_W-1:0]  frame_i,
    input  logic                     load_low_i,
    input  logic                     ld_fall_i,
    input  logic                     clr_fall_i,
    input  logic [IO_W-1:0]          io_pin_i,
    output logic [NCH*CODE_W-1:0]    data_o,
    output logic [CODE_W-1:0]        rd_data_o,
    output logic [IO_W-1:0]          io_out_o,
    output logic [IO_W-1:0]          io_oe_o
);

    localparam int FW  = CODE_W + HDR_W;
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CODE_W-1:0] in_q   [NCH];
    logic [CODE_W-1:0] data_q [NCH];
    logic [CODE_W-1:0] gain_q [NCH];
    logic [CODE_W-1:0] offs_q [NCH];
    logic [IO_W-1:0]   dir_q, out_q;

    regsel_e           sel_f;
    logic [2:0]        ch_f;
    logic [CODE_W-1:0] pay_f;
    logic              is_wr;
    logic [NCH-1:0]    hit_v;
    logic [CHW-1:0]    idx;
    logic [IO_W-1:0]   lvl;

    assign sel_f = regsel_e'(frame_i[FW-2 -: 4]);
    assign ch_f  = frame_i[CODE_W+2:CODE_W];
    assign pay_f = frame_i[CODE_W-1:0];
    assign is_wr = frame_ok_i && !frame_i[FW-1];
    assign idx   = ch_f[CHW-1:0];
    assign lvl   = (dir_q & out_q) | (~dir_q & io_pin_i);

    always_comb begin
        for (int i = 0; i < NCH; i++)
            hit_v[i] = (ch_f == CH_ALL) || (ch_f == 3'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                in_q[i]   <= '0;
                data_q[i] <= '0;
                gain_q[i] <= '0;
                offs_q[i] <= '0;
            end
            dir_q <= '0;
            out_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (clr_fall_i)
                    data_q[i] <= '0;
                else if (is_wr && sel_f == SEL_DATA && hit_v[i] && load_low_i)
                    data_q[i] <= pay_f;
                else if (ld_fall_i)
                    data_q[i] <= in_q[i];
                if (is_wr && sel_f == SEL_DATA && hit_v[i]) in_q[i]   <= pay_f;
                if (is_wr && sel_f == SEL_GAIN && hit_v[i]) gain_q[i] <= pay_f;
                if (is_wr && sel_f == SEL_OFFS && hit_v[i]) offs_q[i] <= pay_f;
            end
            if (is_wr && sel_f == SEL_FUNC) begin
                dir_q <= pay_f[2*IO_W-1:IO_W];
                out_q <= pay_f[IO_W-1:0];
            end
        end
    end

    // readback selection
    always_comb begin
        rd_data_o = '0;
        case (sel_f)
            SEL_DATA: if (ch_f < 3'(NCH)) rd_data_o = data_q[idx];
            SEL_GAIN: if (ch_f < 3'(NCH)) rd_data_o = gain_q[idx];
            SEL_OFFS: if (ch_f < 3'(NCH)) rd_data_o = offs_q[idx];
            SEL_FUNC: rd_data_o[2*IO_W-1:0] = {dir_q, lvl};
            default:  rd_data_o = '0;
        endcase
    end

    assign io_out_o = out_q;
    assign io_oe_o  = dir_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign data_o[g*CODE_W +: CODE_W] = data_q[g];

        // R5
        clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_fall_i |=> (data_q[g] == '0));

        // R3
        load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_fall_i && !clr_fall_i && !frame_ok_i) |=> (data_q[g] == $past(in_q[g])));

        // R2
        data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(frame_ok_i || ld_fall_i || clr_fall_i) |=> $stable(data_q[g]));
    end

endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
    import qdac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int CODE_W      = 16,
    parameter int IO_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_n,
    input  logic                  sclk,
    input  logic                  sdin,
    input  logic                  load_n,
    input  logic                  clr_n,
    input  logic                  code_ob,
    input  logic                  hold_n,
    input  logic [IO_W-1:0]       io_in,
    output logic                  sdo,
    output logic [IO_W-1:0]       io_out,
    output logic [IO_W-1:0]       io_oe,
    output logic                  clamp,
    output logic [NCH*CODE_W-1:0] ch_code
);

    localparam int FW   = CODE_W + HDR_W;
    localparam int SW   = 6 + IO_W;
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
    // bit order: io, hold_n, sdin, clr_n, load_n, sclk, sync_n
    localparam logic [SW-1:0] SYNC_RST = {{IO_W{1'b0}}, 6'b101111};

    logic [SW-1:0]         sync_q;
    logic [3:0]            edge_prev_q;
    logic                  sync_s, sclk_s, load_s, clr_s, sdin_s, hold_s;
    logic [IO_W-1:0]       io_s;
    logic                  sync_fall, sync_rise, sclk_fall, sclk_rise, ld_fall, clr_fall;
    logic [FW-1:0]         frame;
    logic                  frame_ok;
    logic [CODE_W-1:0]     rd_data;
    logic [NCH*CODE_W-1:0] data_flat;

    qdac_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({io_in, hold_n, sdin, clr_n, load_n, sclk, sync_n}),
        .q_o   (sync_q)
    );

    assign {io_s, hold_s, sdin_s, clr_s, load_s, sclk_s, sync_s} = sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) edge_prev_q <= 4'b1111;
        else        edge_prev_q <= {clr_s, load_s, sclk_s, sync_s};
    end

    assign sync_fall = edge_prev_q[0] & ~sync_s;
    assign sync_rise = ~edge_prev_q[0] & sync_s;
    assign sclk_fall = edge_prev_q[1] & ~sclk_s;
    assign sclk_rise = ~edge_prev_q[1] & sclk_s;
    assign ld_fall   = edge_prev_q[2] & ~load_s;
    assign clr_fall  = edge_prev_q[3] & ~clr_s;

    qdac_frame_rx #(.CODE_W(CODE_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_fall_i (sync_fall),
        .sync_rise_i (sync_rise),
        .sclk_fall_i (sclk_fall),
        .sclk_rise_i (sclk_rise),
        .sdin_i      (sdin_s),
        .rd_data_i   (rd_data),
        .frame_o     (frame),
        .frame_ok_o  (frame_ok),
        .sdo_o       (sdo)
    );

    qdac_regfile #(.NCH(NCH), .CODE_W(CODE_W), .IO_W(IO_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_ok_i (frame_ok),
        .frame_i    (frame),
        .load_low_i (~load_s),
        .ld_fall_i  (ld_fall),
        .clr_fall_i (clr_fall),
        .io_pin_i   (io_s),
        .data_o     (data_flat),
        .rd_data_o  (rd_data),
        .io_out_o   (io_out),
        .io_oe_o    (io_oe)
    );

    assign clamp = ~hold_s;

    for (genvar g = 0; g < NCH; g++) begin : g_out
        logic [CODE_W-1:0] raw;
        assign raw = data_flat[g*CODE_W +: CODE_W];
        assign ch_code[g*CODE_W +: CODE_W] =
            !hold_s ? MID_CODE :
            code_ob ? raw : {~raw[CODE_W-1], raw[CODE_W-2:0]};
    end

endmodule

// File: tb/quad_dac_ctrl_tb_top.sv
module quad_dac_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
    logic        load_n = 1'b0, clr_n = 1'b1, code_ob = 1'b1, hold_n = 1'b1;
    logic [1:0]  io_in = 2'b00;
    logic        sdo;
    logic [1:0]  io_out, io_oe;
    logic        clamp;
    logic [63:0] ch_code;

    int tests = 0;
    int fails = 0;
    bit settled = 0;
    bit done = 0;

    // reference model state
    logic [15:0] in_m [4];
    logic [15:0] data_m [4];

    always #10 clk = ~clk;

    quad_dac_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .load_n(load_n), .clr_n(clr_n), .code_ob(code_ob), .hold_n(hold_n),
        .io_in(io_in), .sdo(sdo), .io_out(io_out), .io_oe(io_oe),
        .clamp(clamp), .ch_code(ch_code)
    );

    function automatic logic [63:0] exp_codes();
        logic [63:0] v;
        for (int i = 0; i < 4; i++) begin
            if (!hold_n)      v[i*16 +: 16] = 16'h8000;
            else if (code_ob) v[i*16 +: 16] = data_m[i];
            else              v[i*16 +: 16] = data_m[i] ^ 16'h8000;
        end
        return v;
    endfunction

    function automatic logic [23:0] mk(bit rd, logic [3:0] sel, logic [2:0] ch, logic [15:0] p);
        return {rd, sel, ch, p};
    endfunction

    // lock-step comparison of the outputs against the model (R2, R6)
    always @(negedge clk) begin
        if (settled && rst_n && !done) begin
            tests++;
            if (ch_code !== exp_codes() || clamp !== !hold_n) begin
                fails++;
                $display("FAIL R2 R6 lockstep: ch_code=%h clamp=%b expected %h clamp=%b",
                         ch_code, clamp, exp_codes(), !hold_n);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [71:0] w, input int n, output logic [71:0] cap);
        cap = '0;
        settled = 0;
        sync_n = 1'b0;
        tick(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = w[i];
            tick(4);
            cap = {cap[70:0], sdo};
            sclk = 1'b0;
            tick(4);
            sclk = 1'b1;
        end
        tick(4);
        sync_n = 1'b1;
        tick(8);
    endtask

    // model of a committed write frame
    task automatic mdl_apply(input logic [23:0] w);
        if (!w[23] && w[22:19] == 4'd1) begin
            for (int i = 0; i < 4; i++) begin
                if (w[18:16] == 3'd4 || w[18:16] == 3'(i)) begin
                    in_m[i] = w[15:0];
                    if (!load_n) data_m[i] = w[15:0];
                end
            end
        end
    endtask

    task automatic wr(input logic [23:0] w, output logic [23:0] seen);
        logic [71:0] c;
        xfer({48'h0, w}, 24, c);
        mdl_apply(w);
        seen = c[23:0];
        settled = 1;
        tick(2);
    endtask

    task automatic settle_pins();
        settled = 0;
        tick(8);
        settled = 1;
        tick(2);
    endtask

    initial begin
        logic [23:0] s;
        logic [71:0] c;
        for (int i = 0; i < 4; i++) begin in_m[i] = '0; data_m[i] = '0; end
        tick(5);
        rst_n = 1'b1;
        tick(6);
        settled = 1;
        // R13 reset state
        chk("R13 codes", ch_code, 64'h0);
        chk("R13 sdo", {63'h0, sdo}, 64'h0);
        chk("R13 io_oe", {62'h0, io_oe}, 64'h0);
        chk("R13 clamp", {63'h0, clamp}, 64'h0);

        // R1 R2 immediate update
        wr(mk(0, 4'd1, 3'd0, 16'h1234), s);
        chk("R1 R2 ch0", {48'h0, ch_code[15:0]}, 64'h1234);

        // R9 daisy pass-through
        wr(mk(0, 4'd1, 3'd2, 16'hBEEF), s);
        wr(mk(0, 4'd1, 3'd1, 16'h0F0F), s);
        chk("R9 passthrough", {40'h0, s}, 64'h0ABEEF);
        chk("R2 ch2", {48'h0, ch_code[47:32]}, 64'hBEEF);

        // R3 deferred load
        load_n = 1'b1;
        settle_pins();
        wr(mk(0, 4'd1, 3'd3, 16'h7777), s);
        wr(mk(0, 4'd1, 3'd0, 16'h5555), s);
        chk("R3 deferred", ch_code, 64'h0000_BEEF_0F0F_1234);
        load_n = 1'b0;
        settled = 0;
        for (int i = 0; i < 4; i++) data_m[i] = in_m[i];
        settle_pins();
        chk("R3 load all", ch_code, 64'h7777_BEEF_0F0F_5555);

        // R4 all-channel write, codes 5..7 touch nothing
        wr(mk(0, 4'd1, 3'd4, 16'hA5A5), s);
        chk("R4 all", ch_code, 64'hA5A5_A5A5_A5A5_A5A5);
        wr(mk(0, 4'd1, 3'd6, 16'h1111), s);
        chk("R4 none", ch_code, 64'hA5A5_A5A5_A5A5_A5A5);

        // R6 two's complement view
        code_ob = 1'b0;
        settle_pins();
        chk("R6 twos", ch_code, 64'h25A5_25A5_25A5_25A5);

        // R5 clear
        settled = 0;
        clr_n = 1'b0;
        for (int i = 0; i < 4; i++) data_m[i] = '0;
        tick(4);
        clr_n = 1'b1;
        settle_pins();
        chk("R5 clear twos", ch_code, 64'h8000_8000_8000_8000);
        code_ob = 1'b1;
        settle_pins();
        chk("R5 clear ob", ch_code, 64'h0);

        // R7 clamp keeps registers
        hold_n = 1'b0;
        settle_pins();
        chk("R7 clamp", {ch_code[63:1], clamp}, {63'h4000_4000_4000_4000, 1'b1});
        wr(mk(0, 4'd1, 3'd1, 16'h4321), s);
        chk("R7 still clamped", ch_code, 64'h8000_8000_8000_8000);
        hold_n = 1'b1;
        settle_pins();
        chk("R7 release", ch_code, 64'h0000_0000_4321_0000);

        // R8 bad lengths discarded, 48 accepted
        xfer({48'h0, mk(0, 4'd1, 3'd0, 16'hFFFF)}, 10, c);
        settled = 1; tick(2);
        chk("R8 10 bits", {48'h0, ch_code[15:0]}, 64'h0);
        xfer({42'h0, 6'b101010, mk(0, 4'd1, 3'd0, 16'hFFFF)}, 30, c);
        settled = 1; tick(2);
        chk("R8 30 bits", {48'h0, ch_code[15:0]}, 64'h0);
        xfer({24'h0, 24'h000000, mk(0, 4'd1, 3'd0, 16'h2222)}, 48, c);
        mdl_apply(mk(0, 4'd1, 3'd0, 16'h2222));
        settled = 1; tick(2);
        chk("R8 48 bits", {48'h0, ch_code[15:0]}, 64'h2222);

        // R11 R10 gain / offset / data readback
        wr(mk(0, 4'd2, 3'd1, 16'h1111), s);
        wr(mk(0, 4'd3, 3'd2, 16'h3333), s);
        wr(mk(1, 4'd2, 3'd1, 16'h0), s);
        wr(24'h0, s);
        chk("R11 R10 gain1", {40'h0, s}, 64'h911111);
        wr(mk(1, 4'd3, 3'd2, 16'h0), s);
        wr(24'h0, s);
        chk("R11 offs2", {40'h0, s}, 64'h9A3333);
        wr(mk(1, 4'd2, 3'd2, 16'h0), s);
        wr(24'h0, s);
        chk("R11 gain2 untouched", {40'h0, s}, 64'h920000);
        wr(mk(1, 4'd1, 3'd1, 16'h0), s);
        wr(24'h0, s);
        chk("R10 data1", {40'h0, s}, 64'h894321);

        // R12 function register
        wr(mk(0, 4'd4, 3'd0, 16'h000D), s);
        chk("R12 dir/out a", {60'h0, io_oe, io_out}, 64'hD);
        wr(mk(0, 4'd4, 3'd0, 16'h0007), s);
        chk("R12 dir/out b", {60'h0, io_oe, io_out}, 64'h7);
        wr(mk(1, 4'd4, 3'd0, 16'h0), s);
        wr(24'h0, s);
        chk("R12 read pins low", {40'h0, s}, 64'hA00005);
        io_in = 2'b10;
        tick(6);
        wr(mk(1, 4'd4, 3'd0, 16'h0), s);
        wr(24'h0, s);
        chk("R12 read pins high", {40'h0, s}, 64'hA00007);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule